// File: doc/BRIEF.md
# Coarse Depth Tile Store With Fast-Clear

This block keeps one conservative 16-bit unsigned-normalized depth value for every screen tile. An upstream rasterizer sends it tile test requests, each carrying a tile index, a fragment depth and a compare direction. For each request the block returns a pass or reject verdict, so that fragments that are certain to fail the full-resolution depth test can be dropped early. Depth-writing draws send update requests. The block accepts an update only when the draw's test mode is enabled in a programmable feedback mask. An accepted update moves the tile value only in the safe direction, toward the farther depth.

A one-bit-per-tile dirty map gives a clear that finishes in one cycle. While the map is in use, a tile whose bit is 0 is still "cleared" and is tested against a programmable clear depth. The first update to such a tile seeds it with the safe extreme for the update's direction before merging, and then marks the tile dirty. The map is consulted only while the fast-clear enable is high.

Both request streams use valid/ready. A test is accepted when `tst_valid && tst_ready`. Its verdict is held in a single output register, so `tst_ready` drops only while a verdict is pending and `res_ready` is low. Updates never stall (`upd_ready` is always high). Control inputs (enable, clear, clear depth, mask) are plain level signals sampled on each rising clock edge.

Top module: `coarse_depth_store`

## Requirements
- R1: After a synchronous active-low reset, `res_valid` is 0, every dirty bit is 0 and every stored tile value equals 0xFFFF.
- R2: Direction encoding is 0 = LESS and 1 = GREATER. Under LESS a test passes exactly when depth <= reference. Under GREATER it passes exactly when depth >= reference.
- R3: With the fast-clear enable high, a tile whose dirty bit is 0 uses the clear depth as its test reference. A dirty tile uses its stored value.
- R4: With the fast-clear enable low, the dirty map is neither read nor written. Tests use the stored value, updates leave the bits unchanged, and a clear command has no effect.
- R5: An update is applied only if bit `upd_mode` of `fb_mask` is 1. Otherwise it changes no tile value and no dirty bit.
- R6: An applied update sets the tile to max(base, depth) under LESS and to min(base, depth) under GREATER.
- R7: With the enable high, an update to a tile whose dirty bit is 0 uses base 0x0000 under GREATER or 0xFFFF under LESS, and then sets the bit to 1. Otherwise the base is the stored value.
- R8: A clear command with the enable high zeroes every dirty bit in one cycle. A test accepted in the same cycle sees the cleared state. An update in the same cycle is seeded as for a cleared tile and leaves its bit set.
- R9: A verdict appears on `res_valid`/`res_pass` in the cycle after acceptance. It is held unchanged while `res_ready` is low. `tst_ready` equals `!res_valid || res_ready`.
- R10: A test accepted in the same cycle as an update to the same tile uses the tile state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fc_enable | input | 1 | Enables use of the dirty map |
| clear_cmd | input | 1 | One-cycle clear of the whole dirty map |
| clear_value | input | 16 | Depth reported by cleared tiles |
| fb_mask | input | 8 | One enable bit per test mode for updates |
| tst_valid | input | 1 | Test request valid |
| tst_ready | output | 1 | Test request ready |
| tst_tile | input | 6 | Tile index of the test |
| tst_depth | input | 16 | Fragment depth of the test |
| tst_dir | input | 1 | Compare direction of the test (0 LESS, 1 GREATER) |
| res_valid | output | 1 | Verdict valid |
| res_ready | input | 1 | Verdict ready |
| res_pass | output | 1 | 1 = pass, 0 = reject |
| upd_valid | input | 1 | Update request valid |
| upd_ready | output | 1 | Update ready (always high) |
| upd_tile | input | 6 | Tile index of the update |
| upd_depth | input | 16 | Depth written by the draw |
| upd_dir | input | 1 | Compare direction of the draw (0 LESS, 1 GREATER) |
| upd_mode | input | 3 | Test mode of the draw, indexes `fb_mask` |

## Verification
The assertions assume that `res_ready` is a free input from downstream and that the control inputs are stable between rising edges. They also assume that a test request, once offered, may be withdrawn without harm, because verdict ordering only concerns accepted requests. The bench changes every input shortly after a rising edge, so each edge sees settled values. It drives `res_ready` both steadily high and in random stalls, so verdicts are held under back-pressure as well as drained freely. Random phases confine most tile indices to a handful of tiles, which makes same-cycle test/update/clear collisions frequent. They also toggle the fast-clear enable only occasionally, so long stretches exercise the map in both modes.

// File: rtl/cds_pkg.sv
package cds_pkg;

  // Compare direction carried by tests and updates
  typedef enum logic {
    CMP_LESS    = 1'b0,
    CMP_GREATER = 1'b1
  } cmp_dir_e;

endpackage

// File: rtl/cds_clear_map.sv
// One dirty bit per tile. Bit 0 = tile still holds the clear depth.
// Outputs tell each reader whether the stored tile value is authoritative.
module cds_clear_map #(
  parameter int NUM_TILES = 64,
  localparam int IDX_W = $clog2(NUM_TILES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fc_en,
  input  logic             clear_cmd,
  input  logic [IDX_W-1:0] rd_idx_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  output logic             use_stored_a,
  output logic             use_stored_b
);

  logic [NUM_TILES-1:0] dirty_q;

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dirty_q[t] <= 1'b0;
      end else if (fc_en) begin
        // a same-cycle update is ordered after the clear, so it wins
        if (set_en && (set_idx == IDX_W'(t))) begin
          dirty_q[t] <= 1'b1;
        end else if (clear_cmd) begin
          dirty_q[t] <= 1'b0;
        end
      end
    end
  end

  // clear is visible to readers in the cycle it is issued
  assign use_stored_a = !fc_en || (!clear_cmd && dirty_q[rd_idx_a]);
  assign use_stored_b = !fc_en || (!clear_cmd && dirty_q[rd_idx_b]);

endmodule

// File: rtl/cds_tile_bank.sv
// Register bank of per-tile conservative depths with two read ports
// and one write port.
module cds_tile_bank #(
  parameter int          NUM_TILES   = 64,
  parameter int          DEPTH_W     = 16,
  parameter logic [15:0] RESET_DEPTH = 16'hFFFF,
  localparam int IDX_W = $clog2(NUM_TILES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   rd_idx_a,
  input  logic [IDX_W-1:0]   rd_idx_b,
  output logic [DEPTH_W-1:0] rd_data_a,
  output logic [DEPTH_W-1:0] rd_data_b,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DEPTH_W-1:0] wr_data
);

  logic [DEPTH_W-1:0] depth_q [NUM_TILES];

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        depth_q[t] <= DEPTH_W'(RESET_DEPTH);
      end else if (wr_en && (wr_idx == IDX_W'(t))) begin
        depth_q[t] <= wr_data;
      end
    end
  end

  assign rd_data_a = depth_q[rd_idx_a];
  assign rd_data_b = depth_q[rd_idx_b];

endmodule

// File: rtl/cds_update_unit.sv
// Combinational merge of an update into a tile value.
// Cleared tiles are seeded with the safe extreme for the direction.
module cds_update_unit
  import cds_pkg::*;
#(
  parameter int DEPTH_W = 16
) (
  input  logic [DEPTH_W-1:0] stored,
  input  logic               use_stored,
  input  cmp_dir_e           dir,
  input  logic [DEPTH_W-1:0] depth,
  output logic [DEPTH_W-1:0] merged
);

  localparam logic [DEPTH_W-1:0] NEAR_ZERO = '0;
  localparam logic [DEPTH_W-1:0] FAR_ONE   = '1;

  logic [DEPTH_W-1:0] base;

  always_comb begin
    if (use_stored) begin
      base = stored;
    end else if (dir == CMP_GREATER) begin
      base = NEAR_ZERO;
    end else begin
      base = FAR_ONE;
    end

    if (dir == CMP_GREATER) begin
      merged = (depth < base) ? depth : base;
    end else begin
      merged = (depth > base) ? depth : base;
    end
  end

endmodule

// File: rtl/cds_test_stage.sv
// Compare plus single-entry verdict register with valid/ready.
module cds_test_stage
  import cds_pkg::*;
#(
  parameter int DEPTH_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [DEPTH_W-1:0] req_depth,
  input  cmp_dir_e           req_dir,
  input  logic [DEPTH_W-1:0] ref_depth,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_pass
);

  logic verdict;

  always_comb begin
    if (req_dir == CMP_GREATER) begin
      verdict = (req_depth >= ref_depth);
    end else begin
      verdict = (req_depth <= ref_depth);
    end
  end

  assign req_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pass  <= 1'b0;
    end else if (req_valid && req_ready) begin
      out_valid <= 1'b1;
      out_pass  <= verdict;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/coarse_depth_store.sv
module coarse_depth_store
  import cds_pkg::*;
#(
  parameter int          NUM_TILES   = 64,
  parameter int          DEPTH_W     = 16,
  parameter int          NUM_MODES   = 8,
  parameter logic [15:0] RESET_DEPTH = 16'hFFFF,
  localparam int IDX_W  = $clog2(NUM_TILES),
  localparam int MODE_W = $clog2(NUM_MODES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fc_enable,
  input  logic                 clear_cmd,
  input  logic [DEPTH_W-1:0]   clear_value,
  input  logic [NUM_MODES-1:0] fb_mask,
  input  logic                 tst_valid,
  output logic                 tst_ready,
  input  logic [IDX_W-1:0]     tst_tile,
  input  logic [DEPTH_W-1:0]   tst_depth,
  input  logic                 tst_dir,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic                 res_pass,
  input  logic                 upd_valid,
  output logic                 upd_ready,
  input  logic [IDX_W-1:0]     upd_tile,
  input  logic [DEPTH_W-1:0]   upd_depth,
  input  logic                 upd_dir,
  input  logic [MODE_W-1:0]    upd_mode
);

  logic               tst_use_stored;
  logic               upd_use_stored;
  logic [DEPTH_W-1:0] tst_stored;
  logic [DEPTH_W-1:0] upd_stored;
  logic [DEPTH_W-1:0] tst_ref;
  logic [DEPTH_W-1:0] upd_merged;
  logic               upd_apply;

  assign upd_ready = 1'b1;
  assign upd_apply = upd_valid && fb_mask[upd_mode];

  cds_clear_map #(
    .NUM_TILES(NUM_TILES)
  ) map_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fc_en       (fc_enable),
    .clear_cmd   (clear_cmd),
    .rd_idx_a    (tst_tile),
    .rd_idx_b    (upd_tile),
    .set_en      (upd_apply),
    .set_idx     (upd_tile),
    .use_stored_a(tst_use_stored),
    .use_stored_b(upd_use_stored)
  );

  cds_tile_bank #(
    .NUM_TILES  (NUM_TILES),
    .DEPTH_W    (DEPTH_W),
    .RESET_DEPTH(RESET_DEPTH)
  ) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx_a (tst_tile),
    .rd_idx_b (upd_tile),
    .rd_data_a(tst_stored),
    .rd_data_b(upd_stored),
    .wr_en    (upd_apply),
    .wr_idx   (upd_tile),
    .wr_data  (upd_merged)
  );

  cds_update_unit #(
    .DEPTH_W(DEPTH_W)
  ) merge_i (
    .stored    (upd_stored),
    .use_stored(upd_use_stored),
    .dir       (cmp_dir_e'(upd_dir)),
    .depth     (upd_depth),
    .merged    (upd_merged)
  );

  assign tst_ref = tst_use_stored ? tst_stored : clear_value;

  cds_test_stage #(
    .DEPTH_W(DEPTH_W)
  ) test_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(tst_valid),
    .req_ready(tst_ready),
    .req_depth(tst_depth),
    .req_dir  (cmp_dir_e'(tst_dir)),
    .ref_depth(tst_ref),
    .out_valid(res_valid),
    .out_ready(res_ready),
    .out_pass (res_pass)
  );

endmodule

// File: rtl/cds_checker.sv
module cds_checker #(
  parameter int DEPTH_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fc_enable,
  input logic               clear_cmd,
  input logic [DEPTH_W-1:0] clear_value,
  input logic               tst_valid,
  input logic               tst_ready,
  input logic [DEPTH_W-1:0] tst_depth,
  input logic               tst_dir,
  input logic               res_valid,
  input logic               res_ready,
  input logic               res_pass
);

  // R9: stalled verdict stays put
  assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_pass)));

  // R9: an accepted test yields a verdict on the next cycle
  assert_verdict_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_valid && tst_ready) |=> res_valid);

  // R9: a fresh verdict always follows an acceptance
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(tst_valid && tst_ready));

  // R8: a test issued with a clear sees the clear depth
  assert_clear_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_enable && clear_cmd && tst_valid && tst_ready) |=>
      (res_pass == ($past(tst_dir) ? ($past(tst_depth) >= $past(clear_value))
                                   : ($past(tst_depth) <= $past(clear_value)))));

endmodule

bind coarse_depth_store cds_checker #(.DEPTH_W(DEPTH_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .fc_enable  (fc_enable),
  .clear_cmd  (clear_cmd),
  .clear_value(clear_value),
  .tst_valid  (tst_valid),
  .tst_ready  (tst_ready),
  .tst_depth  (tst_depth),
  .tst_dir    (tst_dir),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_pass   (res_pass)
);

// File: tb/coarse_depth_store_tb_top.sv
`timescale 1ns/1ps
module coarse_depth_store_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fc_enable = 1'b0;
  logic        clear_cmd = 1'b0;
  logic [15:0] clear_value = 16'h0;
  logic [7:0]  fb_mask = 8'h0;
  logic        tst_valid = 1'b0;
  logic        tst_ready;
  logic [5:0]  tst_tile = 6'd0;
  logic [15:0] tst_depth = 16'h0;
  logic        tst_dir = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_pass;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [5:0]  upd_tile = 6'd0;
  logic [15:0] upd_depth = 16'h0;
  logic        upd_dir = 1'b0;
  logic [2:0]  upd_mode = 3'd0;

  always #2.5 clk = ~clk;

  coarse_depth_store dut_i (
    .clk(clk), .rst_n(rst_n), .fc_enable(fc_enable), .clear_cmd(clear_cmd),
    .clear_value(clear_value), .fb_mask(fb_mask),
    .tst_valid(tst_valid), .tst_ready(tst_ready), .tst_tile(tst_tile),
    .tst_depth(tst_depth), .tst_dir(tst_dir),
    .res_valid(res_valid), .res_ready(res_ready), .res_pass(res_pass),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_tile(upd_tile),
    .upd_depth(upd_depth), .upd_dir(upd_dir), .upd_mode(upd_mode)
  );

  int    errors = 0;
  int    checks = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  int m_val [64];
  bit m_bit [64];
  bit m_rv;
  bit m_rp;

  task automatic check(input string req, input int actual, input int expected, input string what);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, actual, expected, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin
        m_val[i] = 16'hFFFF;
        m_bit[i] = 1'b0;
      end
      m_rv = 1'b0;
      m_rp = 1'b0;
    end else begin
      bit fire;
      bit p;
      int v;
      if (clear_cmd && fc_enable) begin
        for (int i = 0; i < 64; i++) m_bit[i] = 1'b0;
      end
      fire = tst_valid && (!m_rv || res_ready);
      p = 1'b0;
      if (fire) begin
        v = (fc_enable && !m_bit[tst_tile]) ? int'(clear_value) : m_val[tst_tile];
        p = tst_dir ? (int'(tst_depth) >= v) : (int'(tst_depth) <= v);
      end
      if (m_rv && res_ready) m_rv = 1'b0;
      if (fire) begin
        m_rv = 1'b1;
        m_rp = p;
      end
      if (upd_valid && fb_mask[upd_mode]) begin
        int b;
        if (fc_enable && !m_bit[upd_tile]) b = upd_dir ? 0 : 16'hFFFF;
        else b = m_val[upd_tile];
        if (upd_dir) m_val[upd_tile] = (int'(upd_depth) < b) ? int'(upd_depth) : b;
        else         m_val[upd_tile] = (int'(upd_depth) > b) ? int'(upd_depth) : b;
        if (fc_enable) m_bit[upd_tile] = 1'b1;
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        check("R1", int'(res_valid), 0, "res_valid in reset");
      end else begin
        check("R9", int'(tst_ready), int'(!m_rv || res_ready), "tst_ready");
        check(tag, int'(res_valid), int'(m_rv), "res_valid");
        if (m_rv) check(tag, int'(res_pass), int'(m_rp), "res_pass");
        check("R9", int'(upd_ready), 1, "upd_ready");
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    tst_valid = 1'b0;
    upd_valid = 1'b0;
    clear_cmd = 1'b0;
  endtask

  task automatic test(input int tile, input int depth, input bit dir);
    tst_valid = 1'b1; tst_tile = 6'(tile); tst_depth = 16'(depth); tst_dir = dir;
    step();
    tst_valid = 1'b0;
  endtask

  task automatic upd(input int tile, input int depth, input bit dir, input int mode);
    upd_valid = 1'b1; upd_tile = 6'(tile); upd_depth = 16'(depth);
    upd_dir = dir; upd_mode = 3'(mode);
    step();
    upd_valid = 1'b0;
  endtask

  initial begin
    step(); step(); step();
    rst_n = 1'b1;
    step();

    // R3: cleared tiles use the clear depth
    tag = "R3"; fc_enable = 1'b1; clear_value = 16'h8000;
    test(3, 16'h7000, 1'b0);
    test(3, 16'h9000, 1'b0);
    test(3, 16'h8000, 1'b1);
    step();

    // R4: map unused when disabled; reset value 0xFFFF is the reference
    tag = "R4"; fc_enable = 1'b0;
    test(3, 16'hFFFF, 1'b0);
    test(3, 16'h0001, 1'b1);
    clear_cmd = 1'b1; step(); clear_cmd = 1'b0;

    // R6 / R2: merges without the map
    tag = "R6"; fb_mask = 8'hFF;
    upd(7, 16'h4000, 1'b1, 0);
    upd(7, 16'h5000, 1'b1, 0);
    upd(7, 16'h2000, 1'b1, 0);
    tag = "R2";
    test(7, 16'h2000, 1'b1);
    test(7, 16'h1FFF, 1'b1);
    test(7, 16'h2000, 1'b0);
    test(7, 16'h2001, 1'b0);
    test(7, 16'h0000, 1'b0);

    // R5: masked mode leaves the tile alone
    tag = "R5"; fb_mask = 8'b0000_0101;
    upd(9, 16'h1000, 1'b1, 1);
    test(9, 16'h1000, 1'b1);
    upd(9, 16'h1000, 1'b1, 2);
    test(9, 16'h1000, 1'b1);
    test(9, 16'h0FFF, 1'b1);

    // R7: seeding of cleared tiles with the map enabled
    tag = "R7"; fc_enable = 1'b1; fb_mask = 8'hFF; clear_value = 16'h6000;
    upd(12, 16'h3000, 1'b1, 3);
    test(12, 16'h0000, 1'b1);
    test(12, 16'h0000, 1'b0);
    upd(13, 16'h3000, 1'b0, 3);
    test(13, 16'hFFFF, 1'b0);
    test(14, 16'h6001, 1'b0);

    // R4: updates with map disabled leave tile 20 clean
    tag = "R4"; fc_enable = 1'b0;
    upd(20, 16'h1234, 1'b1, 0);
    fc_enable = 1'b1;
    test(20, 16'h6000, 1'b1);

    // R8: clear coincident with test and with update
    tag = "R8";
    clear_cmd = 1'b1; test(12, 16'h6000, 1'b1); clear_cmd = 1'b0;
    test(12, 16'h5FFF, 1'b1);
    clear_cmd = 1'b1; upd(12, 16'h7000, 1'b1, 0); clear_cmd = 1'b0;
    test(12, 16'h0000, 1'b1);

    // R10: test and update on the same tile in one cycle
    tag = "R10";
    upd_valid = 1'b1; upd_tile = 6'd30; upd_depth = 16'h0100; upd_dir = 1'b1; upd_mode = 3'd0;
    test(30, 16'h0200, 1'b0);
    upd_valid = 1'b0;
    test(30, 16'h0000, 1'b1);

    // R9: back-pressure on verdicts
    tag = "R9"; res_ready = 1'b0;
    tst_valid = 1'b1; tst_tile = 6'd7; tst_depth = 16'h3000; tst_dir = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      tst_depth = 16'(k);
    end
    tst_valid = 1'b0;
    res_ready = 1'b1;
    step(); step();

    // random mix
    tag = "R10";
    for (int n = 0; n < 3000; n++) begin
      tst_valid   = ($urandom % 3) != 0;
      tst_tile    = ($urandom % 4 == 0) ? 6'($urandom) : 6'($urandom % 8);
      tst_depth   = 16'($urandom);
      tst_dir     = 1'($urandom);
      upd_valid   = ($urandom % 2) != 0;
      upd_tile    = ($urandom % 4 == 0) ? 6'($urandom) : 6'($urandom % 8);
      upd_depth   = 16'($urandom);
      upd_dir     = 1'($urandom);
      upd_mode    = 3'($urandom);
      res_ready   = ($urandom % 4) != 0;
      clear_cmd   = ($urandom % 40) == 0;
      if ($urandom % 200 == 0) fc_enable = ~fc_enable;
      if ($urandom % 100 == 0) fb_mask = 8'($urandom);
      if ($urandom % 150 == 0) clear_value = 16'($urandom);
      step();
    end
    idle();
    res_ready = 1'b1;
    step(); step();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule